// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block watches the write cycles that a parallel programmer drives into a flash device and picks out the three erase commands. Each bus cycle carries an 11-bit address, a data byte and a row/column select. A row cycle supplies the upper 8 bits of a 19-bit internal address, and a column cycle supplies the lower 11 bits. Only a column cycle counts as a command write. It is captured when the active-low write strobe returns high while output enable is inactive.

All three erase commands begin with the same five-write unlock prefix. The sixth write chooses the operation through its data byte: 10h selects a whole-chip erase, 30h a sector erase and 50h a page erase. A sector or page erase takes its target from that sixth write's address. Any write that does not match the expected step drops the tracker back to idle without an error. After a sixth write is accepted, the block stores the erase kind and target address, holds a busy flag for a parameterised number of clocks and then pulses a done flag. While busy, every strobe is ignored.

Top module: `flash_erase_decoder`

## Requirements
- R1: After reset `busy` and `done` are 0, `erase_kind` is 00 (none) and `erase_addr` is 0.
- R2: A strobe with `row_sel`=1 latches `bus_addr[7:0]` as internal address bits [18:11]. A strobe with `row_sel`=0 supplies bits [10:0] from `bus_addr[10:0]`, and the row bits come from the latest row strobe.
- R3: A cycle is taken when `we_n` rises (sampled low on one clock, high on the next) while `oe_n` is 1. A strobe completed while `oe_n` is 0 has no effect on the sequence in progress.
- R4: The six command writes (data at internal address) AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h start a chip erase and set `erase_kind` to 01.
- R5: The same five-write prefix followed by 30h or 50h at any address starts a sector erase (`erase_kind` 10) or a page erase (`erase_kind` 11). The full 19-bit address of that write appears on `erase_addr`.
- R6: Unlock address matching compares only internal bits [14:0]. Row bits [7:4] of the unlock writes are don't-care.
- R7: A command write whose address or data does not match the expected step returns the tracker to idle, and that write does not start a new sequence. A sixth write with any other data starts no erase.
- R8: `busy` rises on the clock edge that accepts the sixth write and stays high for exactly `ERASE_CYCLES` clocks.
- R9: `done` is high for exactly one clock, on the first clock after `busy` falls.
- R10: While `busy` is high, all strobes (row and column) are ignored. `erase_kind` and `erase_addr` keep their values, and no second erase follows.
- R11: `sector_idx` equals `erase_addr[18:16]` and `page_idx` equals `erase_addr[18:12]` (default widths 3 and 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we_n | input | 1 | Active-low write strobe, sampled on clk |
| oe_n | input | 1 | Active-low output enable; writes are taken only when high |
| row_sel | input | 1 | 1 = row address cycle, 0 = column (command) cycle |
| bus_addr | input | 11 | Multiplexed address |
| bus_data | input | 8 | Write data byte |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-clock pulse at erase completion |
| erase_kind | output | 2 | Last erase: 00 none, 01 chip, 10 sector, 11 page |
| erase_addr | output | 19 | Internal address of the last accepted sixth write |
| sector_idx | output | 3 | High-order sector index of erase_addr |
| page_idx | output | 7 | High-order page index of erase_addr |

## Verification
A strobe is recognised on the clock edge after `we_n` is seen low. That edge also updates `busy`, `erase_kind` and `erase_addr`, so these outputs are already valid one clock after the edge where `we_n` goes high. The bench raises `we_n` at a falling edge and checks those outputs at the falling edge that follows. It then counts, at falling edges, the clocks for which `busy` stays high, and expects exactly `ERASE_CYCLES`. `done` is checked at the first falling edge where `busy` reads low and again one edge later. For a rejected sequence, the bench watches `busy` over a window longer than any latency and checks that the stored kind and address are unchanged.

// File: rtl/erase_dec_pkg.sv
package erase_dec_pkg;

    localparam int ROW_W   = 8;
    localparam int COL_W   = 11;
    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int DATA_W  = 8;
    localparam int MATCH_W = 15;
    localparam int PREFIX_LEN = 5;

    localparam logic [MATCH_W-1:0] UNLOCK_HI = 15'h5555;
    localparam logic [MATCH_W-1:0] UNLOCK_LO = 15'h2AAA;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] KEY_SETUP  = 8'h80;
    localparam logic [DATA_W-1:0] OP_CHIP    = 8'h10;
    localparam logic [DATA_W-1:0] OP_SECTOR  = 8'h30;
    localparam logic [DATA_W-1:0] OP_PAGE    = 8'h50;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_CHIP   = 2'b01,
        KIND_SECTOR = 2'b10,
        KIND_PAGE   = 2'b11
    } erase_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_cycle_t;

endpackage

// File: rtl/strobe_capture.sv
module strobe_capture
    import erase_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              row_sel,
    input  logic [COL_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              block,
    output logic              cyc_valid,
    output bus_cycle_t        cyc
);

    typedef struct packed {
        logic             we_prev;
        logic [ROW_W-1:0] row;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       accept;

    always_comb begin
        st_d         = st_q;
        st_d.we_prev = we_n;
        accept       = we_n && !st_q.we_prev && oe_n && !block;
        if (accept && row_sel) begin
            st_d.row = bus_addr[ROW_W-1:0];
        end
        cyc_valid = accept && !row_sel;
        cyc.addr  = {st_q.row, bus_addr};
        cyc.data  = bus_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.we_prev <= 1'b1;
            st_q.row     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a column write reaches the tracker only while output enable is inactive
    p_write_needs_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> oe_n && $past(!we_n))
        else $error("p_write_needs_oe_r3");

endmodule

// File: rtl/erase_seq_tracker.sv
module erase_seq_tracker
    import erase_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  bus_cycle_t        cyc,
    output logic              start,
    output erase_kind_e       kind,
    output logic [ADDR_W-1:0] target
);

    localparam int STAGE_W = $clog2(PREFIX_LEN + 1);
    localparam logic [STAGE_W-1:0] LAST_STAGE = STAGE_W'(PREFIX_LEN);

    typedef struct packed {
        logic [STAGE_W-1:0] stage;
        erase_kind_e        kind;
        logic [ADDR_W-1:0]  target;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic        at_hi, at_lo;
    logic        step_ok;
    erase_kind_e op_kind;

    always_comb begin
        at_hi = cyc.addr[MATCH_W-1:0] == UNLOCK_HI;
        at_lo = cyc.addr[MATCH_W-1:0] == UNLOCK_LO;

        unique case (st_q.stage)
            3'd0:    step_ok = at_hi && cyc.data == KEY_FIRST;
            3'd1:    step_ok = at_lo && cyc.data == KEY_SECOND;
            3'd2:    step_ok = at_hi && cyc.data == KEY_SETUP;
            3'd3:    step_ok = at_hi && cyc.data == KEY_FIRST;
            3'd4:    step_ok = at_lo && cyc.data == KEY_SECOND;
            default: step_ok = 1'b0;
        endcase

        if (cyc.data == OP_CHIP && at_hi) begin
            op_kind = KIND_CHIP;
        end else if (cyc.data == OP_SECTOR) begin
            op_kind = KIND_SECTOR;
        end else if (cyc.data == OP_PAGE) begin
            op_kind = KIND_PAGE;
        end else begin
            op_kind = KIND_NONE;
        end

        st_d  = st_q;
        start = 1'b0;
        if (cyc_valid) begin
            if (st_q.stage < LAST_STAGE) begin
                st_d.stage = step_ok ? st_q.stage + 1'b1 : '0;
            end else begin
                st_d.stage = '0;
                if (op_kind != KIND_NONE) begin
                    start       = 1'b1;
                    st_d.kind   = op_kind;
                    st_d.target = cyc.addr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stage  <= '0;
            st_q.kind   <= KIND_NONE;
            st_q.target <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kind   = st_q.kind;
    assign target = st_q.target;

    // R4: an accepted command always leaves a real erase kind stored
    p_start_sets_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> kind != KIND_NONE)
        else $error("p_start_sets_kind_r4");

    // R5: the stored target is the address of the accepting write
    p_target_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> target == $past(cyc.addr))
        else $error("p_target_capture_r5");

    // R7: the tracker never runs past the sixth step
    p_stage_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stage <= LAST_STAGE)
        else $error("p_stage_bound_r7");

endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.done;

    // R8: a start from the tracker raises busy on the same edge
    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy)
        else $error("p_start_busy_r8");

    // R8: busy cannot drop while the count is still running
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && st_q.cnt != '0 |=> busy)
        else $error("p_busy_hold_r8");

    // R9: done follows the falling edge of busy and lasts one clock
    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy))
        else $error("p_done_after_busy_r9");

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("p_done_pulse_r9");

endmodule

// File: rtl/flash_erase_decoder.sv
module flash_erase_decoder
    import erase_dec_pkg::*;
#(
    parameter int ERASE_CYCLES = 64,
    parameter int SECTOR_BITS  = 3,
    parameter int PAGE_BITS    = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_n,
    input  logic                   oe_n,
    input  logic                   row_sel,
    input  logic [10:0]            bus_addr,
    input  logic [7:0]             bus_data,
    output logic                   busy,
    output logic                   done,
    output logic [1:0]             erase_kind,
    output logic [18:0]            erase_addr,
    output logic [SECTOR_BITS-1:0] sector_idx,
    output logic [PAGE_BITS-1:0]   page_idx
);

    logic              cyc_valid;
    bus_cycle_t        cyc;
    logic              start;
    erase_kind_e       kind;
    logic [ADDR_W-1:0] target;

    strobe_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .row_sel   (row_sel),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .block     (busy),
        .cyc_valid (cyc_valid),
        .cyc       (cyc)
    );

    erase_seq_tracker u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_valid (cyc_valid),
        .cyc       (cyc),
        .start     (start),
        .kind      (kind),
        .target    (target)
    );

    erase_timer #(
        .CYCLES (ERASE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    assign erase_kind = kind;
    assign erase_addr = target;
    assign sector_idx = target[ADDR_W-1 -: SECTOR_BITS];
    assign page_idx   = target[ADDR_W-1 -: PAGE_BITS];

    // R10: no write reaches the tracker while an erase runs
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cyc_valid)
        else $error("p_ignore_busy_r10");

    // R10: stored result is frozen while busy
    p_result_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(erase_kind) && $stable(erase_addr))
        else $error("p_result_frozen_r10");

endmodule

// File: tb/flash_erase_decoder_tb.sv
module flash_erase_decoder_tb;

    localparam int NCYC = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        we_n, oe_n, row_sel;
    logic [10:0] bus_addr;
    logic [7:0]  bus_data;
    logic        busy, done;
    logic [1:0]  erase_kind;
    logic [18:0] erase_addr;
    logic [2:0]  sector_idx;
    logic [6:0]  page_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flash_erase_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .oe_n(oe_n), .row_sel(row_sel),
        .bus_addr(bus_addr), .bus_data(bus_data), .busy(busy), .done(done),
        .erase_kind(erase_kind), .erase_addr(erase_addr),
        .sector_idx(sector_idx), .page_idx(page_idx)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input bit rs, input logic [10:0] a, input logic [7:0] d,
                          input bit oe);
        @(negedge clk);
        row_sel = rs; bus_addr = a; bus_data = d; oe_n = oe; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        oe_n = 1'b1;
    endtask

    // R2: row write then column write forms a 19-bit address
    task automatic bus_write(input logic [18:0] addr, input logic [7:0] d);
        strobe(1'b1, {3'b000, addr[18:11]}, 8'h00, 1'b1);
        strobe(1'b0, addr[10:0], d, 1'b1);
    endtask

    function automatic logic [18:0] unlock_addr(input bit hi, input logic [3:0] upper);
        return {upper, hi ? 15'h5555 : 15'h2AAA};
    endfunction

    function automatic logic [7:0] op_byte(input logic [1:0] k);
        case (k)
            2'b01:   return 8'h10;
            2'b10:   return 8'h30;
            default: return 8'h50;
        endcase
    endfunction

    // corrupt: 0 = none, 1..6 = write whose data gets flipped
    task automatic send_seq(input logic [1:0] k, input logic [18:0] tgt,
                            input logic [3:0] upper, input int corrupt);
        logic [18:0] a [6];
        logic [7:0]  d [6];
        a[0] = unlock_addr(1, upper); d[0] = 8'hAA;
        a[1] = unlock_addr(0, upper); d[1] = 8'h55;
        a[2] = unlock_addr(1, upper); d[2] = 8'h80;
        a[3] = unlock_addr(1, upper); d[3] = 8'hAA;
        a[4] = unlock_addr(0, upper); d[4] = 8'h55;
        a[5] = tgt;                   d[5] = op_byte(k);
        for (int i = 0; i < 6; i++) begin
            bus_write(a[i], (corrupt == i + 1) ? (d[i] ^ 8'h0F) : d[i]);
        end
    endtask

    task automatic expect_erase(input string req, input logic [1:0] k,
                                input logic [18:0] tgt);
        int n;
        check(busy === 1'b1, req, busy, 1);
        check(erase_kind === k, req, erase_kind, k);
        check(erase_addr === tgt, req, erase_addr, tgt);
        check(sector_idx === tgt[18:16], "R11", sector_idx, tgt[18:16]);
        check(page_idx === tgt[18:12], "R11", page_idx, tgt[18:12]);
        n = 0;
        while (busy === 1'b1 && n < NCYC + 10) begin
            n++;
            check(done === 1'b0, "R9", done, 0);
            @(negedge clk);
        end
        check(n == NCYC, "R8", n, NCYC);
        check(done === 1'b1, "R9", done, 1);
        @(negedge clk);
        check(done === 1'b0, "R9", done, 0);
    endtask

    task automatic expect_none(input string req, input logic [1:0] k,
                               input logic [18:0] tgt);
        bit seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (busy !== 1'b0) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, req, seen, 0);
        check(erase_kind === k, req, erase_kind, k);
        check(erase_addr === tgt, req, erase_addr, tgt);
    endtask

    initial begin
        int cyc_cnt = 0;
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 150000 && !finished) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [1:0]  lk;
        logic [18:0] la;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; row_sel = 1'b0;
        bus_addr = '0; bus_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy === 1'b0, "R1", busy, 0);
        check(done === 1'b0, "R1", done, 0);
        check(erase_kind === 2'b00, "R1", erase_kind, 0);
        check(erase_addr === 19'h0, "R1", erase_addr, 0);

        // R4: chip erase
        send_seq(2'b01, 19'h05555, 4'h0, 0);
        expect_erase("R4", 2'b01, 19'h05555);

        // R5 / R2: sector erase at an arbitrary address
        send_seq(2'b10, 19'h6_1234, 4'h0, 0);
        expect_erase("R5", 2'b10, 19'h6_1234);

        // R6: page erase with unlock row bits [7:4] set
        send_seq(2'b11, 19'h3_F0A5, 4'hF, 0);
        expect_erase("R6", 2'b11, 19'h3_F0A5);

        // R3: strobe with oe_n low inside the prefix is ignored
        bus_write(unlock_addr(1, 4'h2), 8'hAA);
        bus_write(unlock_addr(0, 4'h2), 8'h55);
        strobe(1'b1, 11'h0FF, 8'h00, 1'b0);
        strobe(1'b0, 11'h7FF, 8'h00, 1'b0);
        bus_write(unlock_addr(1, 4'h2), 8'h80);
        bus_write(unlock_addr(1, 4'h2), 8'hAA);
        bus_write(unlock_addr(0, 4'h2), 8'h55);
        bus_write(19'h4_0123, 8'h30);
        expect_erase("R3", 2'b10, 19'h4_0123);

        // R7: wrong sixth data starts nothing
        send_seq(2'b10, 19'h1_1111, 4'h0, 0);
        expect_erase("R7", 2'b10, 19'h1_1111);
        bus_write(unlock_addr(1, 4'h0), 8'hAA);
        bus_write(unlock_addr(0, 4'h0), 8'h55);
        bus_write(unlock_addr(1, 4'h0), 8'h80);
        bus_write(unlock_addr(1, 4'h0), 8'hAA);
        bus_write(unlock_addr(0, 4'h0), 8'h55);
        bus_write(19'h2_2222, 8'h20);
        expect_none("R7", 2'b10, 19'h1_1111);
        // R7: chip code at a non-unlock address starts nothing
        send_seq(2'b01, 19'h0_1234, 4'h0, 0);
        expect_none("R7", 2'b10, 19'h1_1111);

        // R10: full sequence during busy is dropped
        send_seq(2'b11, 19'h7_7000, 4'h0, 0);
        check(busy === 1'b1, "R10", busy, 1);
        send_seq(2'b10, 19'h0_0F0F, 4'h0, 0);
        while (busy === 1'b1) @(negedge clk);
        check(done === 1'b1, "R10", done, 1);
        expect_none("R10", 2'b11, 19'h7_7000);

        // random sequences, some corrupted
        lk = 2'b11; la = 19'h7_7000;
        for (int it = 0; it < 40; it++) begin
            logic [1:0]  k;
            logic [18:0] t;
            logic [3:0]  up;
            int          cor;
            k  = 2'($urandom_range(1, 3));
            t  = 19'($urandom());
            up = 4'($urandom());
            if (k == 2'b01) t = {up, 15'h5555};
            cor = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 6)) : 0;
            send_seq(k, t, up, cor);
            if (cor == 0) begin
                expect_erase((k == 2'b01) ? "R4" : "R5", k, t);
                lk = k; la = t;
            end else begin
                expect_none("R7", lk, la);
            end
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule